// File: doc/BRIEF.md
# Interruption Delivery and Masking Controller

This block decides which pending interruption request the core takes, and when. There are four request classes: firmware, fault, performance monitor and external. The controller masks each class with the enable bits held in a small processor status register. It picks one winner by fixed priority. On the edge where it takes that winner, it rewrites the status register in a single step.

On the same edge it also does three more things:
- It registers the handler entry address, computed from a table base value and the winner's vector index.
- It latches a cause word, so that a handler shared by several causes can tell which one fired.
- It keeps a copy of the status bits as they were just before delivery.

A return pulse copies that saved status back into the live register. The core sees the result through a one-cycle acknowledge, a one-hot class vector and the redirect address.

Top module: `intr_dispatch`

## Requirements
- R1: After reset, every status bit (`i`, `ic`, `bn`) and every saved bit is 0. `take` is 0, `ack` is 0, `handler_pc` is 0 and `cause` is 0.
- R2: On the edge that delivers an interruption, `i`, `ic` and `bn` all become 0. `take` is high for exactly the cycle that follows that edge.
- R3: An external request is never taken while `i` is 0.
- R4: A performance-monitor request is never taken while `ic` is 0, whatever the value of `i`.
- R5: A firmware request is taken whatever the values of `i` and `ic`.
- R6: When several unmasked requests are pending, the order is firmware, then fault, then performance monitor, then external. `ack` is one-hot, with bit 0 for firmware, bit 1 for fault, bit 2 for performance monitor and bit 3 for external.
- R7: `handler_pc` is the base with its low SLOT_SHIFT+2 bits forced to 0, plus the vector index shifted left by SLOT_SHIFT. The indices are firmware 0, fault 1, performance monitor 2 and external 3.
- R8: `cause` bits [CODE_W+3:CODE_W] hold the one-hot class in the same order as `ack`. Bits [CODE_W-1:0] hold `fault_code` for a fault and 0 for any other class. The word holds its value until the next delivery.
- R9: A delivery copies the pre-delivery `{bn,ic,i}` into the saved status. A `rfi` pulse without a delivery loads the saved bits back into the status register on that edge.
- R10: No delivery happens on the edge that directly follows a delivery, even with a request still held.
- R11: `psr_wr` loads `psr_wdata` (bit 0 `i`, bit 1 `ic`, bit 2 `bn`) only when neither a delivery nor `rfi` occurs on that edge. When both occur, `rfi` wins over a write, and a delivery wins over `rfi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_fw | input | 1 | Firmware-class request |
| req_fault | input | 1 | Fault request |
| fault_code | input | CODE_W | Fault cause code |
| req_pmi | input | 1 | Performance-monitor request |
| req_ext | input | 1 | External interrupt request |
| vec_base | input | ADDR_W | Vector table base value |
| psr_wr | input | 1 | Status register write strobe |
| psr_wdata | input | 3 | Status write data {bn,ic,i} |
| rfi | input | 1 | Return-from-interruption pulse |
| take | output | 1 | Delivery acknowledge / redirect strobe |
| ack | output | 4 | One-hot class taken |
| handler_pc | output | ADDR_W | Handler entry address |
| cause | output | CODE_W+4 | Latched cause word |
| psr_i | output | 1 | External-interrupt enable |
| psr_ic | output | 1 | Interruption-collection enable |
| psr_bn | output | 1 | Register bank select |
| saved_psr | output | 3 | Saved status {bn,ic,i} |

## Verification
A wrong mask or a wrong priority shows one cycle after the request edge: `take` rises when it should not, or `ack` names the wrong class. A status register that is cleared late or restored from the wrong copy shows on `psr_i`, `psr_ic` and `psr_bn` one edge after the delivery or the return. A broken alignment or index shift shows in `handler_pc` in that same first cycle. A stale cause word persists on `cause` until the next delivery overwrites it.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int NCLS = 4;
    localparam int IDX_W = 2;

    typedef struct packed {
        logic bn;
        logic ic;
        logic i;
    } psr_t;

    typedef enum logic [IDX_W-1:0] {
        CLS_FW    = 2'd0,
        CLS_FAULT = 2'd1,
        CLS_PMI   = 2'd2,
        CLS_EXT   = 2'd3
    } cls_e;
endpackage

// File: rtl/intr_select.sv
module intr_select
    import intr_pkg::*;
(
    input  logic [NCLS-1:0]  req,
    input  logic             en_i,
    input  logic             en_ic,
    input  logic             hold,
    output logic             fire,
    output logic [NCLS-1:0]  grant,
    output logic [IDX_W-1:0] idx
);
    logic [NCLS-1:0] elig;

    always_comb begin
        elig            = req;
        elig[CLS_PMI]   = req[CLS_PMI] & en_ic;
        elig[CLS_EXT]   = req[CLS_EXT] & en_i;
        if (hold) elig  = '0;
        grant = '0;
        idx   = '0;
        for (int k = NCLS - 1; k >= 0; k--) begin
            if (elig[k]) begin
                grant    = '0;
                grant[k] = 1'b1;
                idx      = IDX_W'(k);
            end
        end
        fire = |elig;
    end
endmodule

// File: rtl/intr_vector.sv
module intr_vector
    import intr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SLOT_SHIFT = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] entry
);
    localparam int ALIGN = SLOT_SHIFT + IDX_W;

    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        base_al = {base[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
        offs    = {{(ADDR_W-IDX_W){1'b0}}, idx} << SLOT_SHIFT;
        entry   = base_al | offs;
    end
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
    import intr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SLOT_SHIFT = 8,
    parameter int CODE_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_fw,
    input  logic                   req_fault,
    input  logic [CODE_W-1:0]      fault_code,
    input  logic                   req_pmi,
    input  logic                   req_ext,
    input  logic [ADDR_W-1:0]      vec_base,
    input  logic                   psr_wr,
    input  logic [2:0]             psr_wdata,
    input  logic                   rfi,
    output logic                   take,
    output logic [NCLS-1:0]        ack,
    output logic [ADDR_W-1:0]      handler_pc,
    output logic [CODE_W+NCLS-1:0] cause,
    output logic                   psr_i,
    output logic                   psr_ic,
    output logic                   psr_bn,
    output logic [2:0]             saved_psr
);
    localparam int CAUSE_W = CODE_W + NCLS;

    typedef struct packed {
        psr_t                psr;
        psr_t                saved;
        logic                take;
        logic [NCLS-1:0]     ack;
        logic [ADDR_W-1:0]   pc;
        logic [CAUSE_W-1:0]  cause;
    } st_t;

    st_t st_d, st_q;

    logic [NCLS-1:0]   req_vec;
    logic              fire;
    logic [NCLS-1:0]   grant;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] entry;

    always_comb begin
        req_vec            = '0;
        req_vec[CLS_FW]    = req_fw;
        req_vec[CLS_FAULT] = req_fault;
        req_vec[CLS_PMI]   = req_pmi;
        req_vec[CLS_EXT]   = req_ext;
    end

    intr_select u_sel (
        .req   (req_vec),
        .en_i  (st_q.psr.i),
        .en_ic (st_q.psr.ic),
        .hold  (st_q.take),
        .fire  (fire),
        .grant (grant),
        .idx   (idx)
    );

    intr_vector #(
        .ADDR_W     (ADDR_W),
        .SLOT_SHIFT (SLOT_SHIFT)
    ) u_vec (
        .base  (vec_base),
        .idx   (idx),
        .entry (entry)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.ack  = '0;
        if (fire) begin
            st_d.saved = st_q.psr;
            st_d.psr   = '0;
            st_d.take  = 1'b1;
            st_d.ack   = grant;
            st_d.pc    = entry;
            st_d.cause = {grant, (idx == CLS_FAULT) ? fault_code : {CODE_W{1'b0}}};
        end else if (rfi) begin
            st_d.psr = st_q.saved;
        end else if (psr_wr) begin
            st_d.psr = psr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take       = st_q.take;
    assign ack        = st_q.ack;
    assign handler_pc = st_q.pc;
    assign cause      = st_q.cause;
    assign psr_i      = st_q.psr.i;
    assign psr_ic     = st_q.psr.ic;
    assign psr_bn     = st_q.psr.bn;
    assign saved_psr  = st_q.saved;

    assert_take_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!psr_i && !psr_ic && !psr_bn));

    assert_ext_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && grant[CLS_EXT]) |-> st_q.psr.i);

    assert_pmi_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && grant[CLS_PMI]) |-> st_q.psr.ic);

    assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack) && (take == (ack != '0)));

    assert_fw_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fw && !take) |=> (take && ack[CLS_FW]));

    assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    assert_rfi_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi && !fire) |=> ({psr_bn, psr_ic, psr_i} == $past(saved_psr)));
endmodule

// File: tb/intr_dispatch_tb.sv
module intr_dispatch_tb;
    localparam int ADDR_W = 32;
    localparam int SLOT_SHIFT = 8;
    localparam int CODE_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_fw = 0, req_fault = 0, req_pmi = 0, req_ext = 0;
    logic [CODE_W-1:0] fault_code = '0;
    logic [ADDR_W-1:0] vec_base = 32'hDEAD_BEEF;
    logic psr_wr = 0;
    logic [2:0] psr_wdata = '0;
    logic rfi = 0;
    logic take;
    logic [3:0] ack;
    logic [ADDR_W-1:0] handler_pc;
    logic [CODE_W+3:0] cause;
    logic psr_i, psr_ic, psr_bn;
    logic [2:0] saved_psr;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    intr_dispatch #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT), .CODE_W(CODE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_fw(req_fw), .req_fault(req_fault),
        .fault_code(fault_code), .req_pmi(req_pmi), .req_ext(req_ext),
        .vec_base(vec_base), .psr_wr(psr_wr), .psr_wdata(psr_wdata), .rfi(rfi),
        .take(take), .ack(ack), .handler_pc(handler_pc), .cause(cause),
        .psr_i(psr_i), .psr_ic(psr_ic), .psr_bn(psr_bn), .saved_psr(saved_psr)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_pc(input logic [ADDR_W-1:0] b, input int k);
        logic [ADDR_W-1:0] m;
        m = b & ~((ADDR_W'(1) << (SLOT_SHIFT + 2)) - 1);
        return m + (ADDR_W'(k) << SLOT_SHIFT);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_fw = 0; req_fault = 0; req_pmi = 0; req_ext = 0;
        psr_wr = 0; rfi = 0;
        tick();
    endtask

    task automatic set_psr(input logic [2:0] v);
        @(negedge clk);
        psr_wr = 1; psr_wdata = v;
        tick();
        @(negedge clk);
        psr_wr = 0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 psr", {psr_bn, psr_ic, psr_i}, 0);
        chk("R1 saved", saved_psr, 0);
        chk("R1 take/ack", {take, ack}, 0);
        chk("R1 pc/cause", {handler_pc, cause}, 0);
    endtask

    task automatic t_ext_deliver();
        set_psr(3'b111);
        chk("R11 write", {psr_bn, psr_ic, psr_i}, 3'b111);
        @(negedge clk); req_ext = 1;
        tick();
        chk("R2 take", take, 1);
        chk("R2 psr cleared", {psr_bn, psr_ic, psr_i}, 0);
        chk("R6 ack ext", ack, 4'b1000);
        chk("R7 pc ext", handler_pc, exp_pc(vec_base, 3));
        chk("R8 cause ext", cause, {4'b1000, 6'd0});
        chk("R9 saved", saved_psr, 3'b111);
        idle();
        chk("R2 one cycle", take, 0);
        chk("R8 cause held", cause, {4'b1000, 6'd0});
        @(negedge clk); rfi = 1;
        tick();
        chk("R9 restore", {psr_bn, psr_ic, psr_i}, 3'b111);
        idle();
    endtask

    task automatic t_mask_i();
        set_psr(3'b010);
        @(negedge clk); req_ext = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R3 ext masked", take, 0);
        end
        @(negedge clk); req_pmi = 1;
        tick();
        chk("R4 pmi with ic", ack, 4'b0100);
        chk("R7 pc pmi", handler_pc, exp_pc(vec_base, 2));
        idle();
    endtask

    task automatic t_mask_ic();
        set_psr(3'b001);
        @(negedge clk); req_pmi = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 pmi masked", take, 0);
        end
        @(negedge clk); req_ext = 1;
        tick();
        chk("R4 ext passes pmi", ack, 4'b1000);
        idle();
    endtask

    task automatic t_fw_any();
        set_psr(3'b000);
        vec_base = 32'h1234_5678;
        @(negedge clk); req_fw = 1;
        tick();
        chk("R5 fw taken", {take, ack}, 5'b1_0001);
        chk("R7 pc fw", handler_pc, exp_pc(vec_base, 0));
        tick();
        chk("R10 gap", take, 0);
        tick();
        chk("R10 again", {take, ack}, 5'b1_0001);
        idle();
        idle();
    endtask

    task automatic t_priority();
        set_psr(3'b111);
        @(negedge clk); req_fw = 1; req_fault = 1; req_pmi = 1; req_ext = 1; fault_code = 6'h2A;
        tick();
        chk("R6 fw first", ack, 4'b0001);
        idle();
        set_psr(3'b111);
        @(negedge clk); req_fault = 1; req_pmi = 1; req_ext = 1;
        tick();
        chk("R6 fault second", ack, 4'b0010);
        chk("R8 fault code", cause, {4'b0010, 6'h2A});
        chk("R7 pc fault", handler_pc, exp_pc(vec_base, 1));
        idle();
        set_psr(3'b111);
        @(negedge clk); req_pmi = 1; req_ext = 1;
        tick();
        chk("R6 pmi over ext", ack, 4'b0100);
        chk("R8 pmi code zero", cause, {4'b0100, 6'd0});
        idle();
    endtask

    task automatic t_order();
        set_psr(3'b011);
        @(negedge clk); req_fw = 1; rfi = 1; psr_wr = 1; psr_wdata = 3'b101;
        tick();
        chk("R11 deliver wins", {take, psr_bn, psr_ic, psr_i}, 4'b1000);
        chk("R11 saved pre", saved_psr, 3'b011);
        idle();
        @(negedge clk); rfi = 1; psr_wr = 1; psr_wdata = 3'b100;
        tick();
        chk("R11 rfi over write", {psr_bn, psr_ic, psr_i}, 3'b011);
        idle();
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog got=hang exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        @(negedge clk); rst_n = 1;
        tick();
        t_reset();
        t_ext_deliver();
        t_mask_i();
        t_mask_ic();
        t_fw_any();
        t_priority();
        t_order();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule